// File: doc/BRIEF.md
# Elevator Car Motion Controller

This block steers one elevator car toward a target floor. Each cycle it compares the target floor with the floor the car is at. It drives exclusive up and down motor commands and a door-open command, all decoded from one state register. When the car reaches its target, the door is held open for a minimum dwell. The dwell is measured in ticks, and each tick is a parameterised number of clock cycles. The car takes no new direction until the dwell has ended.

A fire alarm input overrides normal service from any state. The car drives down to the ground floor and opens its door there, or it opens the door at once if it is already at or below the ground floor. Request values are ignored for as long as the alarm is high. When the alarm clears, the controller returns to its idle state with the door open and resumes normal service. Floor and target arrive as already-encoded unsigned numbers, so request arbitration and floor sensing live outside this block.

Top module: `lift_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with floor equal to target, the outputs are up_o=0, down_o=0, open_o=1.
- R2: From idle with fire_i low, one cycle after req_i > floor_i the car commands up (up_o=1). One cycle after req_i < floor_i it commands down (down_o=1). With req_i == floor_i it stays idle with open_o=1 and both motor commands low.
- R3: While moving up, up_o=1, down_o=0 and open_o=0 for as long as req_i > floor_i. One cycle after that stops holding, the car enters the door-open state with open_o=1 and both motor commands low.
- R4: While moving down, down_o=1, up_o=0 and open_o=0 for as long as req_i < floor_i. One cycle after that stops holding, the car enters the door-open state.
- R5: Once in the door-open state, the car stays there with open_o=1 and both motors off for DWELL_TICKS*TICK_CYC cycles after the entry cycle, whatever req_i does. With the defaults of 10 ticks of 4 cycles, a waiting request yields 42 samples with the door open and the motors off, counted from the entry edge, before the motor command appears.
- R6: open_o is never 1 in the same cycle as up_o or down_o, and up_o and down_o are never 1 together.
- R7: One cycle after fire_i is seen high in any normal state (idle, up, down, door-open), the car commands down only if floor_i > GROUND_FLOOR. Otherwise it commands door-open only.
- R8: In the fire descent, down_o stays 1 regardless of req_i until floor_i <= GROUND_FLOOR. One cycle after that, the car holds open_o=1 while fire_i stays high.
- R9: One cycle after fire_i is low in either fire state, the controller is idle (open_o=1, motors off), and normal service follows from there.
- R10: The dwell count restarts at zero on every entry to the door-open state. A dwell cut short by the fire alarm does not shorten the next dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| floor_i | input | FLOOR_W | Current floor of the car, unsigned |
| req_i | input | FLOOR_W | Target floor, unsigned |
| fire_i | input | 1 | Fire alarm, active high |
| up_o | output | 1 | Motor command, move up |
| down_o | output | 1 | Motor command, move down |
| open_o | output | 1 | Door-open command |

## Verification
Every output is decoded from the state register. A change on floor_i, req_i or fire_i therefore shows at the outputs exactly one clock edge later. The only longer result is the door dwell: the motor command that follows a dwell appears DWELL_TICKS*TICK_CYC+2 edges after the edge that entered the door-open state. The bench drives its inputs on the falling edge and compares each table row at the next falling edge, which is the first point at which that row's one-edge result is due. For the dwell cases it holds a waiting request and counts falling-edge samples until the first motor command appears, then compares that count with the computed length.

// File: rtl/lift_pkg.sv
package lift_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_UP        = 3'd1,
    ST_DN        = 3'd2,
    ST_DOOR      = 3'd3,
    ST_FIRE_DN   = 3'd4,
    ST_FIRE_OPEN = 3'd5
  } lift_state_e;

  typedef struct packed {
    logic up;
    logic down;
    logic open;
  } lift_cmd_t;

  function automatic lift_cmd_t cmd_of(lift_state_e s);
    lift_cmd_t c;
    c = '{up: 1'b0, down: 1'b0, open: 1'b0};
    unique case (s)
      ST_UP:                 c.up   = 1'b1;
      ST_DN, ST_FIRE_DN:     c.down = 1'b1;
      ST_IDLE, ST_DOOR,
      ST_FIRE_OPEN:          c.open = 1'b1;
      default:               c.open = 1'b1;
    endcase
    return c;
  endfunction

  function automatic logic is_normal(lift_state_e s);
    return (s == ST_IDLE) || (s == ST_UP) || (s == ST_DN) || (s == ST_DOOR);
  endfunction

endpackage

// File: rtl/lift_cmp.sv
module lift_cmp #(
  parameter int FLOOR_W      = 4,
  parameter int GROUND_FLOOR = 1
) (
  input  logic [FLOOR_W-1:0] floor_i,
  input  logic [FLOOR_W-1:0] req_i,
  output logic               req_above_o,
  output logic               req_below_o,
  output logic               above_gnd_o
);
  localparam logic [FLOOR_W-1:0] GND = FLOOR_W'(GROUND_FLOOR);

  assign req_above_o = req_i > floor_i;
  assign req_below_o = req_i < floor_i;
  assign above_gnd_o = floor_i > GND;

endmodule

// File: rtl/lift_dwell.sv
module lift_dwell #(
  parameter int TICK_CYC    = 4,
  parameter int DWELL_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(DWELL_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL_TICKS);

  logic [CNT_W-1:0] ticks_q;
  logic             tick;
  logic             adv;

  assign done_o = (ticks_q == LIMIT);
  assign adv    = run_i && !done_o;

  generate
    if (TICK_CYC <= 1) begin : g_no_pre
      assign tick = adv;
    end else begin : g_pre
      localparam int CYC_W = $clog2(TICK_CYC);
      localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(TICK_CYC - 1);
      logic [CYC_W-1:0] cyc_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cyc_q <= '0;
        else if (clr_i)    cyc_q <= '0;
        else if (adv)      cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
      end

      assign tick = adv && (cyc_q == CYC_LAST);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ticks_q <= '0;
    else if (clr_i)  ticks_q <= '0;
    else if (tick)   ticks_q <= ticks_q + 1'b1;
  end

  a_r5_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticks_q <= LIMIT);

  a_r10_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o);

  a_r5_done_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(run_i));

endmodule

// File: rtl/lift_fsm.sv
module lift_fsm
  import lift_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fire_i,
  input  logic        req_above_i,
  input  logic        req_below_i,
  input  logic        above_gnd_i,
  input  logic        dwell_done_i,
  output lift_state_e state_o,
  output logic        dwell_clr_o,
  output logic        dwell_run_o
);
  lift_state_e state_q, state_d, fire_tgt;

  assign fire_tgt = above_gnd_i ? ST_FIRE_DN : ST_FIRE_OPEN;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fire_i)           state_d = fire_tgt;
        else if (req_above_i) state_d = ST_UP;
        else if (req_below_i) state_d = ST_DN;
      end
      ST_UP: begin
        if (fire_i)            state_d = fire_tgt;
        else if (!req_above_i) state_d = ST_DOOR;
      end
      ST_DN: begin
        if (fire_i)            state_d = fire_tgt;
        else if (!req_below_i) state_d = ST_DOOR;
      end
      ST_DOOR: begin
        if (fire_i)            state_d = fire_tgt;
        else if (dwell_done_i) state_d = ST_IDLE;
      end
      ST_FIRE_DN: begin
        if (!fire_i)           state_d = ST_IDLE;
        else if (!above_gnd_i) state_d = ST_FIRE_OPEN;
      end
      ST_FIRE_OPEN: begin
        if (!fire_i)           state_d = ST_IDLE;
      end
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign dwell_run_o = (state_q == ST_DOOR);
  assign dwell_clr_o = (state_d == ST_DOOR) && (state_q != ST_DOOR);

  a_r7_fire_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && is_normal(state_q) |=> (state_q == ST_FIRE_DN) || (state_q == ST_FIRE_OPEN));

  a_r9_fire_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i && !is_normal(state_q) |=> state_q == ST_IDLE);

  a_r5_dwell_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOOR) && !dwell_done_i && !fire_i |=> state_q == ST_DOOR);

  a_r8_fire_reach_gnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIRE_DN) && fire_i && !above_gnd_i |=> state_q == ST_FIRE_OPEN);

  a_r2_idle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && !fire_i && (req_above_i || req_below_i)
      |=> (state_q == ST_UP) || (state_q == ST_DN));

endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl
  import lift_pkg::*;
#(
  parameter int FLOOR_W      = 4,
  parameter int GROUND_FLOOR = 1,
  parameter int TICK_CYC     = 4,
  parameter int DWELL_TICKS  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FLOOR_W-1:0] floor_i,
  input  logic [FLOOR_W-1:0] req_i,
  input  logic               fire_i,
  output logic               up_o,
  output logic               down_o,
  output logic               open_o
);
  logic        req_above, req_below, above_gnd;
  logic        dwell_clr, dwell_run, dwell_done;
  lift_state_e state;
  lift_cmd_t   cmd;

  lift_cmp #(
    .FLOOR_W      (FLOOR_W),
    .GROUND_FLOOR (GROUND_FLOOR)
  ) u_cmp (
    .floor_i     (floor_i),
    .req_i       (req_i),
    .req_above_o (req_above),
    .req_below_o (req_below),
    .above_gnd_o (above_gnd)
  );

  lift_dwell #(
    .TICK_CYC    (TICK_CYC),
    .DWELL_TICKS (DWELL_TICKS)
  ) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dwell_clr),
    .run_i  (dwell_run),
    .done_o (dwell_done)
  );

  lift_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire_i),
    .req_above_i  (req_above),
    .req_below_i  (req_below),
    .above_gnd_i  (above_gnd),
    .dwell_done_i (dwell_done),
    .state_o      (state),
    .dwell_clr_o  (dwell_clr),
    .dwell_run_o  (dwell_run)
  );

  assign cmd    = cmd_of(state);
  assign up_o   = cmd.up;
  assign down_o = cmd.down;
  assign open_o = cmd.open;

  a_r6_door_interlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_o && (up_o || down_o)));

  a_r6_motor_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && down_o));

  a_r3_up_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o && !fire_i && (req_i > floor_i) |=> up_o);

  a_r4_down_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_o && !fire_i && (req_i < floor_i) |=> down_o);

  a_r1_reset_open: assert property (@(posedge clk_i)
    !rst_ni |-> open_o && !up_o && !down_o);

endmodule

// File: tb/sim_lift_ctrl.sv
module sim_lift_ctrl;
  localparam int FW    = 4;
  localparam int TICK  = 4;
  localparam int DWELL = 10;
  localparam int DWELL_SAMPLES = DWELL * TICK + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] floor_v = 4'd3;
  logic [FW-1:0] req_v = 4'd3;
  logic          fire = 1'b0;
  logic          up, dn, op;
  int            n_vec = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;

  lift_ctrl #(
    .FLOOR_W(FW), .GROUND_FLOOR(1), .TICK_CYC(TICK), .DWELL_TICKS(DWELL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .floor_i(floor_v), .req_i(req_v),
    .fire_i(fire), .up_o(up), .down_o(dn), .open_o(op)
  );

  // {floor, req, fire, up, down, open}; expected = outputs one edge later
  localparam logic [11:0] VEC [24] = '{
    {4'd3, 4'd3, 1'b0, 3'b001},  // R2 equal stays idle
    {4'd3, 4'd5, 1'b0, 3'b100},  // R2 up
    {4'd4, 4'd5, 1'b0, 3'b100},  // R3 hold
    {4'd5, 4'd5, 1'b0, 3'b001},  // R3 arrive
    {4'd5, 4'd5, 1'b1, 3'b010},  // R7 from door, above ground
    {4'd4, 4'd5, 1'b1, 3'b010},  // R8 req ignored
    {4'd2, 4'd9, 1'b1, 3'b010},  // R8
    {4'd1, 4'd9, 1'b1, 3'b001},  // R8 ground reached
    {4'd1, 4'd9, 1'b1, 3'b001},  // R8 hold open
    {4'd1, 4'd9, 1'b0, 3'b001},  // R9 release
    {4'd1, 4'd0, 1'b0, 3'b010},  // R2 down
    {4'd0, 4'd0, 1'b0, 3'b001},  // R4 arrive
    {4'd0, 4'd0, 1'b1, 3'b001},  // R7 below ground -> open
    {4'd0, 4'd7, 1'b0, 3'b001},  // R9 release
    {4'd0, 4'd7, 1'b0, 3'b100},  // R2 up
    {4'd2, 4'd7, 1'b1, 3'b010},  // R7 from up
    {4'd2, 4'd7, 1'b0, 3'b001},  // R9 release from descent
    {4'd2, 4'd1, 1'b0, 3'b010},  // R4 down
    {4'd1, 4'd1, 1'b1, 3'b001},  // R7 from down at ground
    {4'd1, 4'd1, 1'b0, 3'b001},  // R9
    {4'd1, 4'd1, 1'b0, 3'b001},  // R2 idle
    {4'd6, 4'd1, 1'b1, 3'b010},  // R7 from idle
    {4'd1, 4'd1, 1'b1, 3'b001},  // R8
    {4'd1, 4'd1, 1'b0, 3'b001}   // R9
  };

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: up/down/open actual %b expected %b", tag, act, exp);
    end
    if (op && (up || dn)) begin
      n_bad++;
      $display("FAIL R6: door open with motor, actual %b expected no overlap", {up, dn, op});
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_dwell(output int cnt);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (op && (up || dn)) begin
        n_bad++;
        $display("FAIL R6: door open with motor, actual %b expected no overlap", {up, dn, op});
      end
      if (up || dn) break;
      cnt++;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {up, dn, op}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {up, dn, op}, 3'b001);

    for (int i = 0; i < 24; i++) begin
      floor_v = VEC[i][11:8];
      req_v   = VEC[i][7:4];
      fire    = VEC[i][3];
      @(negedge clk);
      chk($sformatf("vec %0d", i), {up, dn, op}, VEC[i][2:0]);
    end

    // R5: full dwell with a waiting request
    floor_v = 4'd1; req_v = 4'd5;
    @(negedge clk);
    chk("R2 start up", {up, dn, op}, 3'b100);
    floor_v = 4'd5; req_v = 4'd0;
    @(negedge clk);
    chk("R3 door entry", {up, dn, op}, 3'b001);
    count_dwell(cnt);
    chk_int("R5 dwell length", cnt + 1, DWELL_SAMPLES);
    chk("R5 down after dwell", {up, dn, op}, 3'b010);

    // R10: dwell cut short by fire, next dwell full length
    floor_v = 4'd0;
    @(negedge clk);
    chk("R4 door entry", {up, dn, op}, 3'b001);
    repeat (5) @(negedge clk);
    chk("R5 still in dwell", {up, dn, op}, 3'b001);
    fire = 1'b1;
    @(negedge clk);
    chk("R7 fire in door", {up, dn, op}, 3'b001);
    fire = 1'b0;
    @(negedge clk);
    chk("R9 idle", {up, dn, op}, 3'b001);
    req_v = 4'd3;
    @(negedge clk);
    chk("R2 up again", {up, dn, op}, 3'b100);
    floor_v = 4'd3; req_v = 4'd0;
    @(negedge clk);
    chk("R10 door entry", {up, dn, op}, 3'b001);
    count_dwell(cnt);
    chk_int("R10 dwell restarted", cnt + 1, DWELL_SAMPLES);

    // R1: asynchronous reset mid-motion
    floor_v = 4'd3; req_v = 4'd9;
    repeat (DWELL_SAMPLES + 2) @(negedge clk);
    chk("R3 moving before reset", {up, dn, op}, 3'b100);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {up, dn, op}, 3'b001);
    req_v = 4'd3;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {up, dn, op}, 3'b001);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule